// File: doc/BRIEF.md
# Observe-Only Scan Test Port

This block is the serial test port of a memory device. A four-wire scan controller (clock, mode select, serial in, serial out, plus an optional asynchronous reset) walks the standard sixteen-state controller, loads a three-bit instruction and then shifts one of three data registers. These are a one-bit bypass cell, a 32-bit identification register and a pad-observation register. The observation register takes a snapshot of the pad input values. It never drives the memory core, and it never preloads output latches.

The instruction set observes only. The all-zeros code and the high-Z sample code both capture the pads like the plain sample code. While either of them is latched, the block also raises a force signal that holds the data I/O buffers at high impedance. The preload half of the sample instruction is absent, so Update-DR does nothing. After reset, and whenever the controller enters Test-Logic-Reset, the identification instruction is latched.

Top module: `scan_tap_observe`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset and the identification code is latched, so `dq_hiz`, `tdo_oe` and `tdo` are all 0. The reset takes effect asynchronously and is released on a TCK rising edge.
- R2: From any state, five TCK rising edges with `tms` high reach Test-Logic-Reset. The edge that enters that state also latches the identification code, so `dq_hiz` drops on that same edge.
- R3: Capture-IR loads the instruction shift stage with 3'b001. The first three bits seen on `tdo` in Shift-IR are therefore 1, 0, 0.
- R4: Shift-IR shifts LSB first, with `tdi` entering the MSB. A shifted code takes effect only on the rising edge that leaves Update-IR. Exit and Pause states leave the active code unchanged.
- R5: Opcodes are 000 all-zeros sample with high-Z, 001 identification, 010 sample with high-Z, 100 sample, and 111 bypass. The reserved codes 011, 101 and 110 route like bypass.
- R6: Under 001, Capture-DR loads the `ID_CODE` parameter. Shift-DR then presents it LSB first, followed by the `tdi` bits.
- R7: Under bypass or a reserved code, Shift-DR gives one 0 first. After that it gives `tdi` delayed by one clock.
- R8: Under 100, 000 or 010, Capture-DR copies `pad_in`. Shift-DR presents `pad_in[0]` first, over a length of `PADS` bits.
- R9: `dq_hiz` is 1 exactly while 000 or 010 is the latched code.
- R10: Update-DR changes no state. The latched code and `dq_hiz` are kept, and the next capture reflects the pads, not the shifted-in bits.
- R11: `tdo` and `tdo_oe` change only on TCK falling edges. `tdo_oe` is 1 only in Shift-IR and Shift-DR; outside those states `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (tie high if unused) |
| tms | input | 1 | Mode select, sampled on TCK rise |
| tdi | input | 1 | Serial data in, sampled on TCK rise |
| pad_in | input | PADS | Pad values observed by the capture register |
| tdo | output | 1 | Serial data out, updated on TCK fall |
| tdo_oe | output | 1 | Output enable for `tdo` |
| dq_hiz | output | 1 | Force data I/O buffers to high impedance |

## Verification
Two actions can land on the same edge. One is the TMS-driven return to Test-Logic-Reset. The other is the loss of a latched high-Z code: the edge that enters the reset state must also restore the identification code. The bench latches the all-zeros code, enters Shift-DR and holds `tms` high. It checks that `dq_hiz` is still 1 after the fourth edge and 0 right after the fifth, and then that a DR shift returns the identification value.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_OBS} dr_sel_e;

  localparam logic [IR_W-1:0] OP_ALLZERO = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e next
);

  always_comb begin
    next = state;
    case (state)
      ST_RESET:  next = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   next = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: next = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: next = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  next = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: next = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: next = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: next = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: next = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: next = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: next = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  next = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: next = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: next = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: next = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: next = tms ? ST_SEL_DR : ST_IDLE;
      default:   next = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= next;
  end

  // run-length of consecutive high mode-select samples, saturating at 7
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)            hi_run <= '0;
    else if (!tms)         hi_run <= '0;
    else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
  end

  // R2
  tms_reset_reach_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run >= 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_instr.sv
module tap_instr
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  tap_state_e next,
  output logic       ir_lsb,
  output dr_sel_e    dr_sel,
  output logic       dq_hiz
);

  logic [IR_W-1:0] ir_sr_q, ir_sr_d;
  logic [IR_W-1:0] instr_q, instr_d;

  always_comb begin
    ir_sr_d = ir_sr_q;
    instr_d = instr_q;
    if (state == ST_CAP_IR)     ir_sr_d = IR_CAPTURE;
    else if (state == ST_SH_IR) ir_sr_d = {tdi, ir_sr_q[IR_W-1:1]};
    if (next == ST_RESET)        instr_d = OP_IDENT;
    else if (state == ST_UPD_IR) instr_d = ir_sr_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr_q <= IR_CAPTURE;
      instr_q <= OP_IDENT;
    end else begin
      ir_sr_q <= ir_sr_d;
      instr_q <= instr_d;
    end
  end

  always_comb begin
    case (instr_q)
      OP_ALLZERO, OP_SAMPZ, OP_SAMPLE: dr_sel = DR_OBS;
      OP_IDENT:                        dr_sel = DR_ID;
      default:                         dr_sel = DR_BYP;
    endcase
    dq_hiz = (instr_q == OP_ALLZERO) || (instr_q == OP_SAMPZ);
  end

  assign ir_lsb = ir_sr_q[0];

  // R3
  ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sr_q[1:0] == 2'b01));

  // R4
  instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && next != ST_RESET) |=> $stable(instr_q));

endmodule

// File: rtl/tap_data.sv
module tap_data
  import scan_tap_pkg::*;
#(
  parameter int               PADS    = 16,
  parameter logic [ID_W-1:0]  ID_CODE = 32'h1A5C_E0F3
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  dr_sel_e         dr_sel,
  input  logic [PADS-1:0] pad_in,
  output logic            dr_lsb
);

  logic            byp_q, byp_d;
  logic [ID_W-1:0] id_q, id_d;
  logic [PADS-1:0] obs_q, obs_d, obs_shifted;

  generate
    if (PADS == 1) begin : g_obs_one
      assign obs_shifted = tdi;
    end else begin : g_obs_many
      assign obs_shifted = {tdi, obs_q[PADS-1:1]};
    end
  endgenerate

  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    obs_d = obs_q;
    if (state == ST_CAP_DR) begin
      case (dr_sel)
        DR_ID:   id_d  = ID_CODE;
        DR_OBS:  obs_d = pad_in;
        default: byp_d = 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (dr_sel)
        DR_ID:   id_d  = {tdi, id_q[ID_W-1:1]};
        DR_OBS:  obs_d = obs_shifted;
        default: byp_d = tdi;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      obs_q <= '0;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
      obs_q <= obs_d;
    end
  end

  always_comb begin
    case (dr_sel)
      DR_ID:   dr_lsb = id_q[0];
      DR_OBS:  dr_lsb = obs_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

  // R7
  bypass_capture_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && dr_sel == DR_BYP) |=> (byp_q == 1'b0));

  // R8
  obs_capture_pads_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && dr_sel == DR_OBS) |=> (obs_q == $past(pad_in)));

  // R10
  update_dr_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_DR) |=> ($stable(obs_q) && $stable(id_q) && $stable(byp_q)));

endmodule

// File: rtl/scan_tap_observe.sv
module scan_tap_observe
  import scan_tap_pkg::*;
#(
  parameter int              PADS    = 16,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5C_E0F3
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [PADS-1:0] pad_in,
  output logic            tdo,
  output logic            tdo_oe,
  output logic            dq_hiz
);

  // asynchronous assertion, release aligned to a TCK rising edge
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e state, next;
  logic       ir_lsb, dr_lsb, hiz_int;
  dr_sel_e    dr_sel;

  tap_ctrl u_ctrl (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state),
    .next  (next)
  );

  tap_instr u_instr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .next   (next),
    .ir_lsb (ir_lsb),
    .dr_sel (dr_sel),
    .dq_hiz (hiz_int)
  );

  tap_data #(.PADS(PADS), .ID_CODE(ID_CODE)) u_data (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .dr_sel (dr_sel),
    .pad_in (pad_in),
    .dr_lsb (dr_lsb)
  );

  logic shifting, out_bit;
  always_comb begin
    shifting = (state == ST_SH_IR) || (state == ST_SH_DR);
    out_bit  = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      tdo    <= shifting ? out_bit : 1'b0;
    end
  end

  assign dq_hiz = hiz_int;

  // R11
  oe_only_in_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  // R9
  hiz_rise_on_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(dq_hiz) |-> ($past(state) == ST_UPD_IR));

  // R11
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_oe |-> !tdo);

endmodule

// File: tb/scan_tap_observe_test.sv
module scan_tap_observe_test;

  localparam int          PADS = 16;
  localparam logic [31:0] IDV  = 32'h1A5C_E0F3;
  localparam int          DRN  = 40;

  typedef struct packed {
    logic [2:0]      op;
    logic [PADS-1:0] pad;
    logic            hiz;
    logic [1:0]      kind;  // 0 bypass, 1 ident, 2 observe
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{op:3'b000, pad:16'hA5C3, hiz:1'b1, kind:2'd2},
    '{op:3'b001, pad:16'h1234, hiz:1'b0, kind:2'd1},
    '{op:3'b010, pad:16'h0F0F, hiz:1'b1, kind:2'd2},
    '{op:3'b011, pad:16'hFFFF, hiz:1'b0, kind:2'd0},
    '{op:3'b100, pad:16'h8001, hiz:1'b0, kind:2'd2},
    '{op:3'b101, pad:16'h0000, hiz:1'b0, kind:2'd0},
    '{op:3'b110, pad:16'h7E7E, hiz:1'b0, kind:2'd0},
    '{op:3'b111, pad:16'h5555, hiz:1'b0, kind:2'd0}
  };

  logic            tck = 1'b0;
  logic            trst_n, tms, tdi;
  logic [PADS-1:0] pads;
  logic            tdo, tdo_oe, dq_hiz;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 tck = ~tck;

  scan_tap_observe #(.PADS(PADS), .ID_CODE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pad_in(pads),
    .tdo(tdo), .tdo_oe(tdo_oe), .dq_hiz(dq_hiz)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // sample outputs after the falling edge, drive inputs, then pass a rising edge
  task automatic step(input logic m, input logic d, output logic o,
                      output logic oe, output logic stable);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck); #1;
    stable = (tdo === o) && (tdo_oe === oe);
  endtask

  task automatic go(input logic m);
    logic o, oe, s;
    step(m, 1'b0, o, oe, s);
  endtask

  // from Run-Test/Idle to Run-Test/Idle
  task automatic ir_load(input logic [2:0] op, output logic [2:0] seen);
    logic o, oe, s;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], o, oe, s);
      seen[i] = o;
    end
    go(1); go(0);
  endtask

  task automatic dr_run(input logic [DRN-1:0] din, output logic [DRN-1:0] dout,
                        output bit oe_ok, output bit stab_ok);
    logic o, oe, s;
    oe_ok = 1; stab_ok = 1;
    go(1); go(0); go(0);
    for (int i = 0; i < DRN; i++) begin
      step(i == DRN-1, din[i], o, oe, s);
      dout[i] = o;
      if (oe !== 1'b1) oe_ok = 0;
      if (!s) stab_ok = 0;
    end
    go(1); go(0);
  endtask

  function automatic logic [DRN-1:0] expect_dr(input logic [1:0] kind,
      input logic [PADS-1:0] pad, input logic [DRN-1:0] din);
    logic [DRN-1:0] r;
    int len;
    logic [63:0] cap;
    case (kind)
      2'd1:    begin len = 32;   cap = {32'h0, IDV}; end
      2'd2:    begin len = PADS; cap = {{(64-PADS){1'b0}}, pad}; end
      default: begin len = 1;    cap = 64'h0; end
    endcase
    for (int i = 0; i < DRN; i++) r[i] = (i < len) ? cap[i] : din[i-len];
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] kind);
    case (kind)
      2'd1:    return "R6";
      2'd2:    return "R8";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [2:0]     seen;
    logic [DRN-1:0] dout, din, exp;
    bit             oe_ok, st_ok;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pads = 16'h0;
    repeat (3) @(posedge tck);
    #2;
    // R1 reset state
    check(dq_hiz === 1'b0, "R1", "dq_hiz in reset", dq_hiz, 0);
    check(tdo_oe === 1'b0, "R1", "tdo_oe in reset", tdo_oe, 0);
    check(tdo === 1'b0, "R1", "tdo in reset", tdo, 0);
    trst_n = 1'b1;
    go(1); go(1); go(1); go(0);
    check(tdo_oe === 1'b0 && tdo === 1'b0, "R11", "idle outputs", {tdo_oe, tdo}, 0);
    // R1 ident is the default instruction
    din = 40'hB4_96E1_D27C;
    dr_run(din, dout, oe_ok, st_ok);
    exp = expect_dr(2'd1, '0, din);
    check(dout === exp, "R1", "default ident shift", dout, exp);

    // R5 table walk over every opcode
    for (int v = 0; v < 8; v++) begin
      ir_load(TBL[v].op, seen);
      check(seen === 3'b001, "R3", "captured IR pattern", seen, 3'b001);
      check(dq_hiz === TBL[v].hiz, "R9", "dq_hiz per opcode", dq_hiz, TBL[v].hiz);
      pads = TBL[v].pad;
      din  = 40'hB4_96E1_D27C ^ {v[7:0], 32'h3C5A_0F96 * (v + 1)};
      dr_run(din, dout, oe_ok, st_ok);
      exp = expect_dr(TBL[v].kind, TBL[v].pad, din);
      check(dout === exp, req_of(TBL[v].kind), "DR shift for opcode (R5)", dout, exp);
      check(oe_ok, "R11", "tdo_oe high through shift", oe_ok, 1);
      check(st_ok, "R11", "tdo steady across rising edge", st_ok, 1);
      check(dq_hiz === TBL[v].hiz, "R10", "dq_hiz after Update-DR", dq_hiz, TBL[v].hiz);
    end

    // R4 staged code waits for Update-IR (bypass is latched now)
    go(1); go(1); go(0); go(0);
    go(0); go(0); go(1);       // shift 000, leave on Exit1-IR
    go(0); go(0);              // Pause-IR
    check(dq_hiz === 1'b0, "R4", "code not applied in Pause-IR", dq_hiz, 0);
    go(1); go(1);              // Exit2-IR, Update-IR
    check(dq_hiz === 1'b0, "R4", "code not applied entering Update-IR", dq_hiz, 0);
    go(0);
    check(dq_hiz === 1'b1, "R4", "code applied leaving Update-IR", dq_hiz, 1);

    // R10 Update-DR loads nothing: next capture shows the pads
    pads = 16'hC0DE;
    din  = 40'hFF_FFFF_FFFF;
    dr_run(din, dout, oe_ok, st_ok);
    pads = 16'h2468;
    din  = 40'h00_0000_0000;
    dr_run(din, dout, oe_ok, st_ok);
    exp = expect_dr(2'd2, 16'h2468, din);
    check(dout === exp, "R10", "recapture after Update-DR", dout, exp);
    check(dq_hiz === 1'b1, "R10", "dq_hiz kept after Update-DR", dq_hiz, 1);

    // R2 five TMS-high edges from Shift-DR; ident restored on the fifth
    go(1); go(0); go(0);
    go(1); go(1); go(1); go(1);
    check(dq_hiz === 1'b1, "R2", "dq_hiz after four edges", dq_hiz, 1);
    go(1);
    check(dq_hiz === 1'b0, "R2", "dq_hiz on entering reset state", dq_hiz, 0);
    go(0);
    din = 40'h5A_A55A_A55A;
    dr_run(din, dout, oe_ok, st_ok);
    exp = expect_dr(2'd1, '0, din);
    check(dout === exp, "R2", "ident after TMS reset", dout, exp);

    // R1 asynchronous reset drops a latched high-Z code at once
    ir_load(3'b010, seen);
    check(dq_hiz === 1'b1, "R9", "sample-Z latched", dq_hiz, 1);
    @(negedge tck); #1;
    trst_n = 1'b0;
    #1;
    check(dq_hiz === 1'b0, "R1", "async reset clears dq_hiz", dq_hiz, 0);
    trst_n = 1'b1;
    go(1); go(1); go(1); go(0);
    check(tdo_oe === 1'b0 && tdo === 1'b0, "R11", "idle outputs after reset", {tdo_oe, tdo}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule